// File: doc/BRIEF.md
# Reference Selection and Clock Divider Router

This block is the digital control of a two-stage frequency translator: it picks one of two reference clocks, divides the chosen one by a power of two for the first loop's phase comparison, and drives two independent output channels from a common high-rate source through per-channel dividers. Clocks are modelled as one-cycle strobes on a single system clock. The high-rate multiplied clock, normally produced by a ×32 analog multiplier, arrives as the input strobe `mulStb`. Each output strobe stands in for one output clock period.

A 3-bit input code sets the reference divide ratio, or selects one of two bypass routes. In one route the first loop is skipped and the multiplier still feeds the outputs. In the other both stages are skipped and the selected reference drives the output dividers itself. Each output channel decodes its own 3-bit code into a divide ratio, a high-impedance state, or a forced static level. Whenever a code that governs a divider changes, that divider restarts from zero, so no shortened period is ever emitted.

Top module: `refdiv_router`

## Requirements
- R1: `refSel` = 0 takes the reference strobes from `refStb[0]`; `refSel` = 1 takes them from `refStb[1]`.
- R2: `inCode` values 0 to 5 make `refDivStb` pulse once for every 2^`inCode` selected reference strobes (ratios 1, 2, 4, 8, 16 and 32). The pulse comes one cycle after the strobe that completes the count.
- R3: `inCode` = 6 keeps `refDivStb` at 0 and feeds both output dividers from `mulStb`. For `inCode` 0 to 5 the output dividers are also fed from `mulStb`.
- R4: `inCode` = 7 keeps `refDivStb` at 0 and feeds both output dividers directly from the selected reference strobe.
- R5: Channel codes 1, 2, 3, 4, 5 and 6 divide the source by 32, 8, 4, 16, 2 and 1. The channel strobe pulses one cycle after the source strobe that completes the count.
- R6: Channel code 0 holds that channel's output-enable flag (`oeA`/`oeB`) low and its strobe at 0.
- R7: Channel code 7 raises that channel's static-level flag (`holdA`/`holdB`: true leg low, complement high). It keeps output-enable high and the strobe at 0.
- R8: The two channels are independent: changing one channel's code does not disturb the count or strobes of the other.
- R9: At ratio 1, every source strobe appears on the channel strobe exactly one cycle later.
- R10: A change of a divider's governing code restarts that divider from zero, and a source strobe in the change cycle is ignored. Governing codes are the channel's own code plus `inCode`/`refSel` for a channel, and `inCode`/`refSel` for the reference divider. The first strobe after the change therefore follows a full new period.
- R11: While `rstN` is low, every strobe output and every flag output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refSel | input | 1 | Reference choice |
| refStb | input | 2 | Edge strobes of the two references |
| mulStb | input | 1 | Strobe standing in for the multiplied clock |
| inCode | input | 3 | Reference divider / bypass code |
| codeA | input | 3 | Channel A code |
| codeB | input | 3 | Channel B code |
| refDivStb | output | 1 | Divided reference for the first loop |
| stbA | output | 1 | Channel A output strobe |
| oeA | output | 1 | Channel A output enable |
| holdA | output | 1 | Channel A static-level flag |
| stbB | output | 1 | Channel B output strobe |
| oeB | output | 1 | Channel B output enable |
| holdB | output | 1 | Channel B static-level flag |

## Verification
The bench builds the block with its default counter width of five bits, which covers the full ratio range up to 32. A 64-cycle window with `refStb[0]` and `mulStb` pulsing every cycle and `refStb[1]` pulsing every other cycle divides evenly by every ratio. Each table row can therefore be judged on exact strobe counts, and no leftover count carries into the next row. Directed sequences then change a code mid-count and switch the reference mid-count, to show the restart and the dropped coincident strobe.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W = 3;
  localparam int LOG_W  = 3;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic             restart;
    logic             run;
    logic [LOG_W-1:0] shiftLog;
  } divCmd_t;

  // Channel code to log2 of its divide ratio (codes 0 and 7 never run)
  function automatic logic [LOG_W-1:0] chanLog2(input logic [CODE_W-1:0] c);
    case (c)
      3'd1:    chanLog2 = 3'd5;
      3'd2:    chanLog2 = 3'd3;
      3'd3:    chanLog2 = 3'd2;
      3'd4:    chanLog2 = 3'd4;
      3'd5:    chanLog2 = 3'd1;
      default: chanLog2 = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           refSel,
  input  logic [CODE_W-1:0]              inCode,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  chCode,
  output divCmd_t                        inCmd,
  output divCmd_t [NUM_CH-1:0]           chCmd,
  output logic                           routeDirect,
  output logic [NUM_CH-1:0]              chOe,
  output logic [NUM_CH-1:0]              chHold
);
  localparam logic [CODE_W-1:0] LAST_RATIO = 3'd5;
  localparam logic [CODE_W-1:0] BYPASS_ALL = 3'd7;

  logic                          refSelQ;
  logic [CODE_W-1:0]             inCodeQ;
  logic [NUM_CH-1:0][CODE_W-1:0] chCodeQ;
  logic                          pathChg;

  // Code history is captured even in reset so the first change after
  // release is measured against the value actually applied
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSelQ <= refSel;
      inCodeQ <= inCode;
      chCodeQ <= chCode;
      chOe    <= '0;
      chHold  <= '0;
    end else begin
      refSelQ <= refSel;
      inCodeQ <= inCode;
      chCodeQ <= chCode;
      for (int i = 0; i < NUM_CH; i++) begin
        chOe[i]   <= (chCode[i] != '0);
        chHold[i] <= (chCode[i] == BYPASS_ALL);
      end
    end
  end

  assign pathChg     = (inCode != inCodeQ) || (refSel != refSelQ);
  assign routeDirect = (inCode == BYPASS_ALL);

  always_comb begin
    inCmd.restart  = pathChg;
    inCmd.run      = (inCode <= LAST_RATIO);
    inCmd.shiftLog = LOG_W'(inCode);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_comb begin
      chCmd[g].restart  = pathChg || (chCode[g] != chCodeQ[g]);
      chCmd[g].run      = (chCode[g] != '0) && (chCode[g] != BYPASS_ALL);
      chCmd[g].shiftLog = chanLog2(chCode[g]);
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCmd_t cmd,
  input  logic    srcStb,
  output logic    outStb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim = CNT_W'((32'd1 << cmd.shiftLog) - 32'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      outStb <= 1'b0;
    end else if (cmd.restart || !cmd.run) begin
      cnt    <= '0;
      outStb <= 1'b0;
    end else if (srcStb) begin
      if (cnt == lim) begin
        cnt    <= '0;
        outStb <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        outStb <= 1'b0;
      end
    end else begin
      outStb <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_path.sv
module refdiv_path
  import refdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refSel,
  input  logic [1:0]           refStb,
  input  logic                 mulStb,
  input  divCmd_t              inCmd,
  input  divCmd_t [NUM_CH-1:0] chCmd,
  input  logic                 routeDirect,
  output logic                 refDivStb,
  output logic [NUM_CH-1:0]    chStb
);
  logic selRef;
  logic chSrc;

  assign selRef = refStb[refSel];
  assign chSrc  = routeDirect ? selRef : mulStb;

  refdiv_counter #(.CNT_W(CNT_W)) u_refDiv (
    .clk(clk), .rstN(rstN), .cmd(inCmd), .srcStb(selRef), .outStb(refDivStb)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gDiv
    refdiv_counter #(.CNT_W(CNT_W)) u_chDiv (
      .clk(clk), .rstN(rstN), .cmd(chCmd[g]), .srcStb(chSrc), .outStb(chStb[g])
    );
  end
endmodule

// File: rtl/refdiv_router.sv
module refdiv_router #(
  parameter int MAX_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refSel,
  input  logic [1:0] refStb,
  input  logic       mulStb,
  input  logic [2:0] inCode,
  input  logic [2:0] codeA,
  input  logic [2:0] codeB,
  output logic       refDivStb,
  output logic       stbA,
  output logic       oeA,
  output logic       holdA,
  output logic       stbB,
  output logic       oeB,
  output logic       holdB
);
  import refdiv_pkg::*;
  localparam int CNT_W = MAX_LOG2;

  logic [NUM_CH-1:0][CODE_W-1:0] chCode;
  divCmd_t                       inCmd;
  divCmd_t [NUM_CH-1:0]          chCmd;
  logic                          routeDirect;
  logic [NUM_CH-1:0]             chOe;
  logic [NUM_CH-1:0]             chHold;
  logic [NUM_CH-1:0]             chStb;

  assign chCode = {codeB, codeA};

  refdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refSel(refSel), .inCode(inCode), .chCode(chCode),
    .inCmd(inCmd), .chCmd(chCmd), .routeDirect(routeDirect),
    .chOe(chOe), .chHold(chHold)
  );

  refdiv_path #(.CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .refSel(refSel), .refStb(refStb), .mulStb(mulStb),
    .inCmd(inCmd), .chCmd(chCmd), .routeDirect(routeDirect),
    .refDivStb(refDivStb), .chStb(chStb)
  );

  assign stbA  = chStb[0];
  assign stbB  = chStb[1];
  assign oeA   = chOe[0];
  assign oeB   = chOe[1];
  assign holdA = chHold[0];
  assign holdB = chHold[1];
endmodule

// File: rtl/refdiv_router_chk.sv
module refdiv_router_chk (
  input logic       clk,
  input logic       rstN,
  input logic       refSel,
  input logic [1:0] refStb,
  input logic       mulStb,
  input logic [2:0] inCode,
  input logic [2:0] codeA,
  input logic [2:0] codeB,
  input logic       refDivStb,
  input logic       stbA,
  input logic       oeA,
  input logic       holdA,
  input logic       stbB,
  input logic       oeB,
  input logic       holdB
);
  assert_hiz_quiet_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    !oeA |-> !stbA);
  assert_hiz_quiet_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    !oeB |-> !stbB);
  assert_static_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (holdA |-> (oeA && !stbA)) and (holdB |-> (oeB && !stbB)));
  assert_bypass_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inCode == 3'd6) |=> !refDivStb);
  assert_bypass_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inCode == 3'd7) |=> !refDivStb);
  assert_unity_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (codeA == 3'd6 && inCode == 3'd6 && mulStb && $stable(codeA)
     && $stable(inCode) && $stable(refSel)) |=> stbA);
  assert_no_runt_R10: assert property (@(posedge clk) disable iff (!rstN)
    (codeA != $past(codeA)) |=> !stbA);
endmodule

bind refdiv_router refdiv_router_chk u_chk (.*);

// File: tb/refdiv_router_tb.sv
module refdiv_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 64;
  localparam int NVEC = 10;
  // {inCode, codeA, codeB, refSel}
  localparam logic [9:0] VEC [NVEC] = '{
    {3'd0, 3'd6, 3'd5, 1'b0}, {3'd1, 3'd1, 3'd2, 1'b0},
    {3'd2, 3'd3, 3'd4, 1'b1}, {3'd3, 3'd5, 3'd6, 1'b1},
    {3'd4, 3'd0, 3'd7, 1'b0}, {3'd5, 3'd7, 3'd0, 1'b1},
    {3'd6, 3'd2, 3'd1, 1'b0}, {3'd7, 3'd6, 3'd3, 1'b0},
    {3'd7, 3'd5, 3'd4, 1'b1}, {3'd0, 3'd4, 3'd3, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, refSel = 1'b0, mulStb = 1'b0;
  logic [1:0] refStb = '0;
  logic [2:0] inCode = '0, codeA = '0, codeB = '0;
  logic refDivStb, stbA, oeA, holdA, stbB, oeB, holdB;
  int nChecks = 0, nFail = 0, cntR = 0, cntA = 0, cntB = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refdiv_router u_dut (.*);

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    cntR = 0; cntA = 0; cntB = 0;
  endtask

  task automatic step(bit m, bit r0, bit r1);
    @(negedge clk);
    cntR += int'(refDivStb); cntA += int'(stbA); cntB += int'(stbB);
    mulStb = m; refStb = {r1, r0};
  endtask

  function automatic int chLog(logic [2:0] c);
    case (c)
      3'd1: return 5; 3'd2: return 3; 3'd3: return 2;
      3'd4: return 4; 3'd5: return 1; default: return 0;
    endcase
  endfunction

  function automatic int expCh(logic [2:0] ic, logic [2:0] c, logic s);
    int src = (ic == 3'd7) ? (s ? WIN/2 : WIN) : WIN;
    if (c == 3'd0 || c == 3'd7) return 0;
    return src >> chLog(c);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    inCode = 3'd6; codeA = 3'd6; codeB = 3'd6;
    repeat (3) step(1, 1, 1);
    check("R11 reset strobes", int'(refDivStb) + int'(stbA) + int'(stbB), 0);
    check("R11 reset flags", int'(oeA) + int'(holdA) + int'(oeB) + int'(holdB), 0);
    step(0, 0, 0);
    rstN = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] ic, ca, cb;
      logic s;
      {ic, ca, cb, s} = VEC[v];
      step(0, 0, 0);
      inCode = ic; codeA = ca; codeB = cb; refSel = s;
      step(0, 0, 0);
      clr();
      for (int c = 0; c < WIN + 2; c++)
        if (c < WIN) step(1, 1, c % 2 == 0); else step(0, 0, 0);
      check(ic == 3'd7 ? "R4 refDiv idle" : ic == 3'd6 ? "R3 refDiv idle" : "R1 R2 refDiv count",
            cntR, ic <= 3'd5 ? ((s ? WIN/2 : WIN) >> ic) : 0);
      check(ic == 3'd7 ? "R4 chA count" : "R5 R3 chA count", cntA, expCh(ic, ca, s));
      check(ic == 3'd7 ? "R4 chB count" : "R5 R8 chB count", cntB, expCh(ic, cb, s));
      check("R6 oeA", int'(oeA), int'(ca != 3'd0));
      check("R7 holdA", int'(holdA), int'(ca == 3'd7));
      check("R6 oeB", int'(oeB), int'(cb != 3'd0));
      check("R7 holdB", int'(holdB), int'(cb == 3'd7));
    end

    // R9: unity ratio latency
    step(0, 0, 0);
    inCode = 3'd6; codeA = 3'd6; codeB = 3'd0; refSel = 1'b0;
    step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    check("R9 stbA one cycle later", int'(stbA), 1);
    check("R6 chB quiet", int'(stbB) + int'(oeB), 0);
    step(0, 0, 0);
    check("R9 stbA single pulse", int'(stbA), 0);

    // R10 / R8: change A mid-count; B at ratio 1 keeps running
    codeA = 3'd3; codeB = 3'd6;
    step(0, 0, 0); step(0, 0, 0);
    clr();
    repeat (3) step(1, 0, 0);
    step(1, 0, 0);
    codeA = 3'd2;
    repeat (7) step(1, 0, 0);
    step(0, 0, 0);
    check("R10 no runt after change", cntA, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    check("R10 first full period", cntA, 1);
    check("R8 chB undisturbed", cntB, 12);

    // R10 / R1: reference switch restarts input divider
    inCode = 3'd2; codeA = 3'd0; codeB = 3'd0; refSel = 1'b0;
    step(0, 0, 0); step(0, 0, 0);
    clr();
    step(0, 1, 0); step(0, 1, 0);
    step(0, 1, 1);
    refSel = 1'b1;
    repeat (3) step(0, 1, 1);
    step(0, 0, 0);
    check("R10 refDiv restart on switch", cntR, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    check("R1 refDiv from new reference", cntR, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule